// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

In a core that runs several hardware thread contexts at once, one instruction fetch path feeds a separate instruction queue for each context. This block decides, every cycle, which context that fetch path serves. A context may be chosen only when three things hold: software has placed a runnable thread in it, it is not blocked or predicted to block, and its queue is not full. Among the contexts that may be chosen, the one with the fewest decoded micro-ops still waiting in its queue wins. A context that stalls therefore never costs a fetch cycle, because another ready context is taken in the same cycle.

The block keeps one waiting-op counter per context itself. The counter rises on that context's enqueue pulse and falls on its issue pulse. The grant is combinational from the current flags and the registered counters. A rotating pointer, which moves past each winner, breaks ties so that contexts with equal backlog take turns.

Top module: `smt_fetch_picker`

## Requirements
- R1: After reset every waiting-op counter is zero and the tie pointer is at context 0. With all contexts eligible, the first grant is therefore to context 0.
- R2: A context is eligible only when its active bit is 1, its blocked bit is 0 and its full bit is 0. A context that is not eligible is never granted, whatever its count.
- R3: `fetch_grant` has at most one bit set. `fetch_valid` is 1 in the same cycle whenever at least one context is eligible.
- R4: When no context is eligible, `fetch_valid` is 0 and `fetch_grant` is all zeros.
- R5: The granted context has a waiting count no larger than that of any other eligible context.
- R6: Among eligible contexts that share the smallest count, the grant goes to the first one met when scanning upward from the tie pointer, wrapping from N-1 to 0. After a grant, the pointer becomes the winner's index plus one, modulo N. Without a grant, the pointer stays where it is.
- R7: On a clock edge, a counter rises by one when only its enqueue pulse is high and falls by one when only its issue pulse is high. It is unchanged when both pulses are high or both are low.
- R8: A counter at its maximum (63 with 6-bit counters) stays at that maximum on an enqueue-only edge.
- R9: A counter at zero stays at zero on an issue-only edge.
- R10: `wait_cnt` shows the registered counters, with context i at bits [i*CNT_W +: CNT_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctx_active | input | N_CTX | Context holds a runnable thread |
| ctx_blocked | input | N_CTX | Context is blocked or predicted to block |
| ctx_full | input | N_CTX | Context's instruction queue is full |
| enq_pulse | input | N_CTX | One micro-op entered the context's queue |
| iss_pulse | input | N_CTX | One micro-op left the context's queue |
| fetch_grant | output | N_CTX | One-hot selected context, zero when none |
| fetch_valid | output | 1 | Fetch slot is used this cycle |
| wait_cnt | output | N_CTX*CNT_W | Packed per-context waiting-op counters |

## Verification
The bench builds the block with its defaults: four contexts and 6-bit counters. With only four contexts, random eligibility masks often hit the empty set and ties among several contexts. That exercises the rotating pointer at each of its positions. A 6-bit counter fills in about seventy enqueue-only cycles, so a directed phase can drive a counter to its ceiling and push against it. Other phases hold one context at zero while issue pulses arrive, and fire both pulses together. A behavioural model compares grant, valid and every counter on every cycle.

// File: rtl/smt_fetch_pkg.sv
package smt_fetch_pkg;

    localparam int unsigned DEF_CTX   = 4;
    localparam int unsigned DEF_CNT_W = 6;

    // index following idx in a ring of n slots
    function automatic int unsigned ring_next(input int unsigned idx, input int unsigned n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/smt_wait_counter.sv
module smt_wait_counter #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq_i,
    input  logic             iss_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_st_t;

    ctr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (enq_i && !iss_i && st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (iss_i && !enq_i && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    // R8: ceiling holds
    assert_sat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == CNT_MAX && enq_i && !iss_i) |=> cnt_o == CNT_MAX);
    // R9: floor holds
    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == '0 && iss_i && !enq_i) |=> cnt_o == '0);
    // R7: simultaneous pulses cancel
    assert_both_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_i && iss_i) |=> $stable(cnt_o));
    // R7: quiet cycle leaves the count alone
    assert_idle_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!enq_i && !iss_i) |=> $stable(cnt_o));

endmodule

// File: rtl/smt_min_pick.sv
module smt_min_pick #(
    parameter int unsigned N_CTX = 4,
    parameter int unsigned CNT_W = 6,
    localparam int unsigned PTR_W = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
    input  logic [N_CTX-1:0]       elig_i,
    input  logic [N_CTX*CNT_W-1:0] cnt_flat_i,
    input  logic [PTR_W-1:0]       ptr_i,
    output logic [N_CTX-1:0]       grant_o,
    output logic                   valid_o,
    output logic [PTR_W-1:0]       win_o
);
    logic [CNT_W-1:0] cnt_a [N_CTX];

    for (genvar g = 0; g < N_CTX; g++) begin : g_unpack
        assign cnt_a[g] = cnt_flat_i[g*CNT_W +: CNT_W];
    end

    logic              found;
    logic [PTR_W-1:0]  best_idx;
    logic [CNT_W-1:0]  best_cnt;
    int unsigned       slot;

    // scan from the pointer; a strict less-than keeps the earliest tie
    always_comb begin
        found    = 1'b0;
        best_idx = '0;
        best_cnt = '1;
        slot     = 0;
        for (int k = 0; k < N_CTX; k++) begin
            slot = (int'(ptr_i) + k) % N_CTX;
            if (elig_i[slot] && (!found || cnt_a[slot] < best_cnt)) begin
                found    = 1'b1;
                best_idx = PTR_W'(slot);
                best_cnt = cnt_a[slot];
            end
        end
    end

    logic [N_CTX-1:0] one_hot_base;
    assign one_hot_base = {{(N_CTX-1){1'b0}}, 1'b1};

    assign grant_o = found ? (one_hot_base << best_idx) : '0;
    assign valid_o = found;
    assign win_o   = best_idx;

endmodule

// File: rtl/smt_fetch_picker.sv
module smt_fetch_picker #(
    parameter int unsigned N_CTX = smt_fetch_pkg::DEF_CTX,
    parameter int unsigned CNT_W = smt_fetch_pkg::DEF_CNT_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_CTX-1:0]       ctx_active,
    input  logic [N_CTX-1:0]       ctx_blocked,
    input  logic [N_CTX-1:0]       ctx_full,
    input  logic [N_CTX-1:0]       enq_pulse,
    input  logic [N_CTX-1:0]       iss_pulse,
    output logic [N_CTX-1:0]       fetch_grant,
    output logic                   fetch_valid,
    output logic [N_CTX*CNT_W-1:0] wait_cnt
);
    import smt_fetch_pkg::*;

    localparam int unsigned PTR_W = (N_CTX > 1) ? $clog2(N_CTX) : 1;

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } pick_st_t;

    pick_st_t st_d, st_q;

    logic [N_CTX-1:0] elig;
    logic [PTR_W-1:0] win;

    assign elig = ctx_active & ~ctx_blocked & ~ctx_full;

    for (genvar g = 0; g < N_CTX; g++) begin : g_ctr
        smt_wait_counter #(.CNT_W(CNT_W)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .enq_i (enq_pulse[g]),
            .iss_i (iss_pulse[g]),
            .cnt_o (wait_cnt[g*CNT_W +: CNT_W])
        );
    end

    smt_min_pick #(.N_CTX(N_CTX), .CNT_W(CNT_W)) u_pick (
        .elig_i     (elig),
        .cnt_flat_i (wait_cnt),
        .ptr_i      (st_q.ptr),
        .grant_o    (fetch_grant),
        .valid_o    (fetch_valid),
        .win_o      (win)
    );

    always_comb begin
        st_d = st_q;
        if (fetch_valid) begin
            st_d.ptr = PTR_W'(ring_next(int'(win), N_CTX));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: never serve an ineligible context
    assert_grant_eligible_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_grant & ~elig) == '0);
    // R3: at most one grant, and a ready context always gets the slot
    assert_grant_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fetch_grant));
    assert_ready_served_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (elig != '0) |-> (fetch_valid && $countones(fetch_grant) == 1));
    // R4: nothing eligible, nothing fetched
    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (elig == '0) |-> (!fetch_valid && fetch_grant == '0));
    // R6: pointer holds when no grant
    assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> $stable(st_q.ptr));

    // R5: winner's backlog is a minimum over the eligible set
    for (genvar w = 0; w < N_CTX; w++) begin : g_minw
        for (genvar j = 0; j < N_CTX; j++) begin : g_minj
            assert_min_backlog_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (fetch_grant[w] && elig[j]) |->
                (wait_cnt[w*CNT_W +: CNT_W] <= wait_cnt[j*CNT_W +: CNT_W]));
        end
    end

endmodule

// File: tb/tb_smt_fetch_picker.sv
`timescale 1ns/1ps
module tb_smt_fetch_picker;

    localparam int NC   = 4;
    localparam int CW   = 6;
    localparam int CMAX = 63;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NC-1:0]   act, blk, full, enq, iss;
    logic [NC-1:0]   fetch_grant;
    logic            fetch_valid;
    logic [NC*CW-1:0] wait_cnt;

    always #4 clk = ~clk;   // 125 MHz

    smt_fetch_picker #(.N_CTX(NC), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n),
        .ctx_active(act), .ctx_blocked(blk), .ctx_full(full),
        .enq_pulse(enq), .iss_pulse(iss),
        .fetch_grant(fetch_grant), .fetch_valid(fetch_valid),
        .wait_cnt(wait_cnt)
    );

    int n_vec  = 0;
    int n_fail = 0;
    int mcnt [NC];
    int mptr;

    function automatic int expected_winner();
        int minv = 1000;
        int win  = -1;
        for (int i = 0; i < NC; i++)
            if (act[i] && !blk[i] && !full[i] && mcnt[i] < minv) minv = mcnt[i];
        for (int k = 0; k < NC; k++) begin
            int idx = (mptr + k) % NC;
            if (win < 0 && act[idx] && !blk[idx] && !full[idx] && mcnt[idx] == minv) win = idx;
        end
        return win;
    endfunction

    task automatic step(input logic [NC-1:0] a, b, f, e, s);
        int w;
        logic [NC-1:0] exp_g;
        @(negedge clk);
        act = a; blk = b; full = f; enq = e; iss = s;
        #1;
        w = expected_winner();
        exp_g = (w >= 0) ? (NC'(1) << w) : '0;
        n_vec++;
        if (fetch_grant !== exp_g) begin
            n_fail++;
            $display("FAIL R2 R5 R6 grant: actual %b expected %b", fetch_grant, exp_g);
        end
        if (fetch_valid !== (w >= 0)) begin
            n_fail++;
            $display("FAIL R3 R4 valid: actual %b expected %b", fetch_valid, (w >= 0));
        end
        for (int i = 0; i < NC; i++)
            if (int'(wait_cnt[i*CW +: CW]) != mcnt[i]) begin
                n_fail++;
                $display("FAIL R7 R8 R9 R10 ctx %0d count: actual %0d expected %0d",
                         i, wait_cnt[i*CW +: CW], mcnt[i]);
            end
        @(posedge clk);
        for (int i = 0; i < NC; i++) begin
            if (e[i] && !s[i] && mcnt[i] < CMAX) mcnt[i]++;
            else if (s[i] && !e[i] && mcnt[i] > 0) mcnt[i]--;
        end
        if (w >= 0) mptr = (w + 1) % NC;
    endtask

    initial begin : watchdog
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        act = '0; blk = '0; full = '0; enq = '0; iss = '0;
        for (int i = 0; i < NC; i++) mcnt[i] = 0;
        mptr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, all eligible -> context 0
        step('1, '0, '0, '0, '0);
        // R6: equal counts rotate 1,2,3,0
        repeat (6) step('1, '0, '0, '0, '0);
        // R4: nothing eligible (inactive, blocked, full mixes)
        step('0, '0, '0, '0, '0);
        step('1, '1, '0, '0, '0);
        step('1, 4'b0011, 4'b1100, '0, '0);
        // R8: push context 0 past its ceiling
        repeat (70) step('1, '0, '0, 4'b0001, '0);
        // R9: drain context 1 below zero
        repeat (3) step('1, '0, '0, '0, 4'b0010);
        // R7: both pulses together on every context
        repeat (4) step('1, '0, '0, '1, '1);
        // R5: context 0 has many queued, build context 2 up, compare
        repeat (5) step('1, '0, '0, 4'b0100, '0);
        repeat (8) step(4'b0101, '0, '0, '0, '0);
        // R2: low-count context made ineligible by its full flag
        repeat (4) step('1, '0, 4'b0010, '0, '0);
        // random mix (R2 R3 R5 R6 R7 R10)
        for (int c = 0; c < 4000; c++) begin
            logic [NC-1:0] ra, rb, rf, re, rs;
            ra = NC'($urandom) | NC'($urandom);
            rb = NC'($urandom) & NC'($urandom);
            rf = NC'($urandom) & NC'($urandom) & NC'($urandom);
            re = NC'($urandom);
            rs = NC'($urandom);
            step(ra, rb, rf, re, rs);
        end
        // drain to zero then push up evenly
        repeat (80) step('1, '0, '0, '0, '1);
        repeat (80) step(4'b1010, 4'b0010, '0, '1, '0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule